// File: doc/BRIEF.md
# Power-Up Configuration Restore Controller

This controller rebuilds a chip's volatile configuration from nonvolatile storage. Each configuration cell has two stages: a staging stage that accepts new data and a live stage that the function actually uses. When the supply is reported good, the controller reads every stored word in address order and writes it only into the staging stages. After the last word it raises one commit pulse, which copies every staging stage into its live stage in the same cycle. A settle delay follows, and then a one-cycle start pulse tells the downstream sequencing engine to fetch its first state.

The states are IDLE, LOAD, COMMIT, SETTLE and DONE. The transitions are as follows. IDLE goes to LOAD when `supply_ok` is high. LOAD goes to COMMIT when the last word is accepted. COMMIT goes to SETTLE after one cycle. SETTLE goes to DONE when the delay expires. DONE goes back to LOAD on `reload_req`. From any state, `supply_ok` low leads to IDLE. While `busy` is high, the bus front end answers every transaction with a not-acknowledge.

A host can send a reload request once the controller is in DONE. This reruns the whole download and overwrites any live edits with the stored contents. The settle delay lasts half a millisecond of the clock and is derived from the `CLK_HZ` parameter.

Top module: `cfg_restore_ctrl`

## Requirements
- R1: After reset, the controller is in IDLE and `busy`, `nv_rd`, `stage_we`, `commit`, `seq_start` and `cfg_ready` are all 0.
- R2: In IDLE, `supply_ok` high moves the controller to LOAD at the next clock edge. `busy` and `nv_rd` then go to 1, with `nv_addr` at 0.
- R3: In LOAD, `nv_addr` holds while `nv_valid` is 0. A cycle with `nv_valid` high is the cycle in which `stage_we` is 1, with `stage_addr` equal to `nv_addr` and `stage_data` equal to `nv_data`. The address then advances by one. Words are written at addresses 0 to WORD_COUNT-1 in ascending order.
- R4: `commit` is high for exactly one cycle. It comes in the cycle right after the write of address WORD_COUNT-1, once all WORD_COUNT words have been written. No `stage_we` occurs after `commit` within the same download.
- R5: `busy` is 1 in every LOAD and COMMIT cycle and 0 in IDLE, SETTLE and DONE.
- R6: `seq_start` is a single-cycle pulse. It comes exactly SETTLE_CYCLES = CLK_HZ/2000 cycles after the `commit` cycle.
- R7: After `seq_start`, `cfg_ready` is 1 and stays 1 until a reload request or a supply drop.
- R8: In DONE, a one-cycle `reload_req` starts a complete new download from address 0, with a new commit and a new start pulse.
- R9: A `reload_req` during LOAD, COMMIT or SETTLE is ignored. The download keeps going without restarting, and exactly one commit occurs.
- R10: `supply_ok` low in any state puts the controller in IDLE at the next edge, with `busy`, `nv_rd` and `cfg_ready` all 0 and no commit. When `supply_ok` returns, the download restarts at address 0.
- R11: `nv_valid` outside LOAD causes no `stage_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above undervoltage lockout |
| reload_req | input | 1 | Host request to rerun the download |
| nv_valid | input | 1 | Read data valid from nonvolatile store |
| nv_data | input | DATA_W | Read data from nonvolatile store |
| nv_addr | output | ADDR_W | Word address to nonvolatile store |
| nv_rd | output | 1 | Read strobe, held until data valid |
| stage_we | output | 1 | Write enable to staging stages |
| stage_addr | output | ADDR_W | Staging write address |
| stage_data | output | DATA_W | Staging write data |
| commit | output | 1 | Global copy of staging to live stages |
| busy | output | 1 | Download active; bus must not-acknowledge |
| seq_start | output | 1 | Pulse telling the sequencer to fetch its first state |
| cfg_ready | output | 1 | Configuration restored and sequencer started |

## Verification
The assertions assume that the store raises `nv_valid` only while `nv_rd` is high, and only for one cycle per address. The bench's store model follows this except in one directed case, which drives `nv_valid` on purpose while in DONE. The assertions also assume that `supply_ok` and `reload_req` change only between clock edges. The bench drives every input on the falling edge to meet this. The store latency is varied from zero to several cycles, so that the address-hold property is exercised.

// File: rtl/cfg_restore_pkg.sv
package cfg_restore_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT,
        ST_SETTLE,
        ST_DONE
    } load_state_t;
endpackage

// File: rtl/cfg_word_counter.sv
module cfg_word_counter #(
    parameter int WORDS = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= last ? '0 : addr + 1'b1;
        end
    end

    assign last = (addr == LAST_ADDR);
endmodule

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
    parameter int CYCLES = 50000,
    parameter int CW     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam logic [CW-1:0] TERMINAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != TERMINAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TERMINAL);
endmodule

// File: rtl/cfg_restore_fsm.sv
module cfg_restore_fsm
    import cfg_restore_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        supply_ok,
    input  logic        reload_req,
    input  logic        nv_valid,
    input  logic        last_word,
    input  logic        settle_expired,
    output load_state_t state_q,
    output logic        busy,
    output logic        rd_en,
    output logic        word_take,
    output logic        commit,
    output logic        seq_start,
    output logic        ready,
    output logic        timer_run
);
    load_state_t state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (supply_ok) state_d = ST_LOAD;
            ST_LOAD:   if (nv_valid && last_word) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_SETTLE;
            ST_SETTLE: if (settle_expired) state_d = ST_DONE;
            ST_DONE:   if (reload_req) state_d = ST_LOAD;
            default:   state_d = ST_IDLE;
        endcase
        if (!supply_ok) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        busy      = 1'b0;
        rd_en     = 1'b0;
        word_take = 1'b0;
        commit    = 1'b0;
        seq_start = 1'b0;
        ready     = 1'b0;
        timer_run = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                busy      = 1'b1;
                rd_en     = 1'b1;
                word_take = nv_valid;
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                commit = 1'b1;
            end
            ST_SETTLE: begin
                timer_run = 1'b1;
                seq_start = settle_expired && supply_ok;
            end
            ST_DONE: ready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_restore_ctrl.sv
module cfg_restore_ctrl
    import cfg_restore_pkg::*;
#(
    parameter int WORD_COUNT = 16,
    parameter int DATA_W     = 8,
    parameter int CLK_HZ     = 100_000_000,
    localparam int ADDR_W        = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1,
    localparam int SETTLE_CYCLES = (CLK_HZ / 2000 > 0) ? CLK_HZ / 2000 : 1,
    localparam int SETTLE_W      = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              reload_req,
    input  logic              nv_valid,
    input  logic [DATA_W-1:0] nv_data,
    output logic [ADDR_W-1:0] nv_addr,
    output logic              nv_rd,
    output logic              stage_we,
    output logic [ADDR_W-1:0] stage_addr,
    output logic [DATA_W-1:0] stage_data,
    output logic              commit,
    output logic              busy,
    output logic              seq_start,
    output logic              cfg_ready
);
    load_state_t state_q;
    logic        last_word;
    logic        settle_expired;
    logic        timer_run;
    logic        word_take;

    cfg_restore_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .reload_req     (reload_req),
        .nv_valid       (nv_valid),
        .last_word      (last_word),
        .settle_expired (settle_expired),
        .state_q        (state_q),
        .busy           (busy),
        .rd_en          (nv_rd),
        .word_take      (word_take),
        .commit         (commit),
        .seq_start      (seq_start),
        .ready          (cfg_ready),
        .timer_run      (timer_run)
    );

    cfg_word_counter #(
        .WORDS (WORD_COUNT),
        .AW    (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!nv_rd),
        .step  (word_take),
        .addr  (nv_addr),
        .last  (last_word)
    );

    cfg_settle_timer #(
        .CYCLES (SETTLE_CYCLES),
        .CW     (SETTLE_W)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (settle_expired)
    );

    assign stage_we   = word_take;
    assign stage_addr = nv_addr;
    assign stage_data = nv_data;
endmodule

// File: rtl/cfg_restore_ctrl_chk.sv
module cfg_restore_ctrl_chk #(
    parameter int WORDS  = 16,
    parameter int AW     = 4,
    parameter int SETTLE = 50000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          nv_valid,
    input logic [AW-1:0] nv_addr,
    input logic          nv_rd,
    input logic          stage_we,
    input logic [AW-1:0] stage_addr,
    input logic          commit,
    input logic          busy,
    input logic          seq_start,
    input logic          cfg_ready
);
    // cycles elapsed since the most recent commit, saturating
    logic [31:0] since_commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           since_commit <= '0;
        else if (commit)                      since_commit <= 32'd1;
        else if (since_commit != 0 && since_commit < 32'hFFFF_FFF0)
                                              since_commit <= since_commit + 32'd1;
    end

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_rd && !nv_valid && supply_ok) |=> (nv_rd && $stable(nv_addr)));

    p_write_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_we |-> (nv_rd && busy && stage_addr == nv_addr));

    p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_commit_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(stage_we) && $past(stage_addr) == AW'(WORDS - 1)));

    p_busy_in_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (busy && !cfg_ready));

    p_settle_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> (since_commit == 32'(SETTLE)));

    p_ready_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && supply_ok) |=> (cfg_ready && !seq_start));

    p_supply_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!busy && !nv_rd && !cfg_ready && !commit));

    p_no_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_rd |-> !stage_we);
endmodule

bind cfg_restore_ctrl cfg_restore_ctrl_chk #(
    .WORDS  (WORD_COUNT),
    .AW     (ADDR_W),
    .SETTLE (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .nv_valid   (nv_valid),
    .nv_addr    (nv_addr),
    .nv_rd      (nv_rd),
    .stage_we   (stage_we),
    .stage_addr (stage_addr),
    .commit     (commit),
    .busy       (busy),
    .seq_start  (seq_start),
    .cfg_ready  (cfg_ready)
);

// File: tb/cfg_restore_ctrl_test.sv
module cfg_restore_ctrl_test;
    localparam int WORDS  = 12;
    localparam int DW     = 8;
    localparam int HZ     = 40_000;
    localparam int SETTLE = HZ / 2000;
    localparam int AW     = $clog2(WORDS);
    localparam int NROWS  = 5;
    // row: [11:8] store latency, [7:0] data seed
    localparam logic [11:0] ROWS [NROWS] = '{
        {4'd0, 8'hA5}, {4'd1, 8'h3C}, {4'd3, 8'h00}, {4'd5, 8'hFF}, {4'd2, 8'h5A}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          reload_req = 1'b0;
    logic          nv_valid = 1'b0;
    logic [DW-1:0] nv_data = '0;
    logic [AW-1:0] nv_addr;
    logic          nv_rd;
    logic          stage_we;
    logic [AW-1:0] stage_addr;
    logic [DW-1:0] stage_data;
    logic          commit;
    logic          busy;
    logic          seq_start;
    logic          cfg_ready;

    cfg_restore_ctrl #(.WORD_COUNT(WORDS), .DATA_W(DW), .CLK_HZ(HZ)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reload_req(reload_req),
        .nv_valid(nv_valid), .nv_data(nv_data), .nv_addr(nv_addr), .nv_rd(nv_rd),
        .stage_we(stage_we), .stage_addr(stage_addr), .stage_data(stage_data),
        .commit(commit), .busy(busy), .seq_start(seq_start), .cfg_ready(cfg_ready)
    );

    always #5 clk = ~clk;

    int       checks = 0;
    int       failures = 0;
    int       cyc = 0;
    int       lat = 0;
    int       wait_cnt = 0;
    logic [7:0] seed = 8'h00;
    bit       inject = 1'b0;
    // monitor state, reset per download
    int       wr_count = 0;
    int       exp_addr = 0;
    int       commits = 0;
    int       commit_cyc = 0;
    int       starts = 0;

    function automatic logic [7:0] pat(input logic [7:0] s, input int a);
        return s ^ 8'(a * 37);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_reset();
        wr_count = 0; exp_addr = 0; commits = 0; starts = 0;
    endtask

    // store model on the falling edge, then monitor the settled outputs
    always @(negedge clk) begin
        cyc++;
        if (inject) begin
            nv_valid = 1'b1;
            nv_data  = 8'hEE;
        end else if (nv_valid) begin
            nv_valid = 1'b0;
            wait_cnt = 0;
        end else if (nv_rd) begin
            if (wait_cnt >= lat) begin
                nv_valid = 1'b1;
                nv_data  = pat(seed, int'(nv_addr));
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
        #1;
        if (stage_we) begin
            check(int'(stage_addr) == exp_addr, "R3 addr", int'(stage_addr), exp_addr);
            check(stage_data == pat(seed, exp_addr), "R3 data", stage_data, pat(seed, exp_addr));
            check(commits == 0, "R4 write after commit", commits, 0);
            wr_count++;
            exp_addr++;
        end
        if (commit) begin
            check(wr_count == WORDS, "R4 words before commit", wr_count, WORDS);
            check(busy == 1'b1, "R5 busy in commit", busy, 1);
            commits++;
            commit_cyc = cyc;
        end
        if (seq_start) begin
            check(cyc - commit_cyc == SETTLE, "R6 settle delay", cyc - commit_cyc, SETTLE);
            starts++;
        end
    end

    task automatic wait_ready();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #2;
            if (cfg_ready) return;
        end
        check(1'b0, "R7 ready timeout", 0, 1);
    endtask

    task automatic pulse_reload();
        @(negedge clk); #2 reload_req = 1'b1;
        @(negedge clk); #2 reload_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check({busy, nv_rd, stage_we, commit, seq_start, cfg_ready} == 6'b0,
              "R1 reset outputs", {busy, nv_rd, stage_we, commit, seq_start, cfg_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check(busy == 1'b0, "R1 idle without supply", busy, 0);

        // table of download runs
        for (int r = 0; r < NROWS; r++) begin
            lat  = int'(ROWS[r][11:8]);
            seed = ROWS[r][7:0];
            run_reset();
            if (r == 0) begin
                @(negedge clk); #2 supply_ok = 1'b1;
                @(negedge clk); #2;
                // R2: load begins at address 0
                check(busy && nv_rd && nv_addr == '0, "R2 load start",
                      {busy, nv_rd, 4'(nv_addr)}, 6'b110000);
            end else begin
                pulse_reload(); // R8 rerun from DONE
            end
            wait_ready();
            check(wr_count == WORDS, "R8 full download", wr_count, WORDS);
            check(commits == 1, "R4 one commit", commits, 1);
            check(starts == 1, "R6 one start", starts, 1);
            check(busy == 1'b0, "R5 busy low in done", busy, 1'b0);
            repeat (4) @(negedge clk);
            #2;
            check(cfg_ready == 1'b1, "R7 ready holds", cfg_ready, 1);
        end

        // R9: reload during LOAD is ignored
        lat = 1; seed = 8'h77;
        run_reset();
        pulse_reload();
        while (exp_addr < 3) begin @(negedge clk); #2; end
        reload_req = 1'b1;
        @(negedge clk); #2 reload_req = 1'b0;
        wait_ready();
        check(wr_count == WORDS && commits == 1, "R9 reload in load", wr_count, WORDS);

        // R9: reload during SETTLE is ignored
        run_reset();
        pulse_reload();
        while (commits == 0) begin @(negedge clk); #2; end
        @(negedge clk); #2 reload_req = 1'b1;
        @(negedge clk); #2 reload_req = 1'b0;
        wait_ready();
        check(wr_count == WORDS && commits == 1 && starts == 1, "R9 reload in settle",
              commits, 1);

        // R10: supply drop mid-load, then restart from 0
        run_reset();
        pulse_reload();
        while (exp_addr < 5) begin @(negedge clk); #2; end
        supply_ok = 1'b0;
        @(negedge clk); #2;
        check({busy, nv_rd, cfg_ready} == 3'b000, "R10 idle after drop",
              {busy, nv_rd, cfg_ready}, 0);
        repeat (5) @(negedge clk);
        #2;
        check(commits == 0, "R10 no commit after drop", commits, 0);
        run_reset();
        supply_ok = 1'b1;
        wait_ready();
        check(wr_count == WORDS && commits == 1, "R10 restart full", wr_count, WORDS);

        // R10: supply drop in DONE
        supply_ok = 1'b0;
        @(negedge clk); #2;
        check(cfg_ready == 1'b0, "R10 ready cleared", cfg_ready, 0);
        run_reset();
        supply_ok = 1'b1;
        wait_ready();

        // R11: data valid outside LOAD has no effect
        run_reset();
        @(negedge clk); #2 inject = 1'b1;
        repeat (3) @(negedge clk);
        #2 inject = 1'b0;
        check(wr_count == 0, "R11 no write in done", wr_count, 0);
        check(cfg_ready == 1'b1 && nv_rd == 1'b0, "R11 state kept", cfg_ready, 1);
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule